// File: doc/BRIEF.md
# Three-Phase Gate Drive Protection Controller

This block sits between the six PWM commands of a three-phase bridge (one high-side and one low-side command per phase) and the six gate enable outputs that reach the drivers. Every input arrives from a comparator or controller pin, so each one passes through a two-flop synchroniser. The command inputs then pass through a minimum-pulse-width filter before the protection logic acts on them. Each output is registered and leaves reset in the off state.

The protection logic blocks shoot-through and applies a global enable. It accepts an over-current trip only once the trip has stayed active for a blanking window. After the trip clears, it keeps every gate off for a fixed hold time. A supply undervoltage forces all gates off and releases as soon as the supply recovers. A high-side undervoltage locks out only that phase's high-side gate, and the lockout holds until that phase's high-side command returns low. An active-low fault flag reports the disable, trip and supply conditions.

The three timing windows are parameters in clock cycles. The defaults assume a 50 MHz clock: 18 cycles of blanking, 100000 cycles of hold (2 ms) and 50 cycles of minimum pulse width (1 µs).

Top module: `gg_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all six gate outputs are 0 and `fault_n` is 0.
- R2: When both commands of a phase are 1 after filtering, both gates of that phase are 0.
- R3: When `en_in` is 0, all six gates are 0 and `fault_n` is 0, whatever the commands are. Gates follow the commands again once `en_in` returns to 1.
- R4: A trip that stays high for fewer than BLANK_CYC synchronised cycles has no effect on the gates or on `fault_n`.
- R5: A trip held high shuts off all six gates and drives `fault_n` to 0. This happens exactly 3+BLANK_CYC clock edges after `trip_in` rises: 2 edges of synchronisation, BLANK_CYC edges of blanking and 1 output register.
- R6: After `trip_in` falls, gates stay off and `fault_n` stays 0 for HOLD_CYC+2 edges. On edge HOLD_CYC+3 normal operation and `fault_n`=1 return.
- R7: While `vdd_uv_in` is 1, all gates are 0 and `fault_n` is 0. This takes effect 3 edges after the change. Release also follows 3 edges after `vdd_uv_in` falls, with no hold time.
- R8: `hs_uv_in[p]`=1 turns off only `gate_hi[p]`, 3 edges after it rises. The lockout stays set after `hs_uv_in[p]` falls and clears only after the filtered `pwm_hi_in[p]` has been 0. `fault_n` is not affected.
- R9: A command level that lasts fewer than MINPW_CYC cycles, whether an on pulse or an off gap, never reaches the outputs.
- R10: A command change held long enough reaches its gate exactly 3+MINPW_CYC edges after the input changes. Bit p of every 3-bit bus belongs to phase p.
- R11: `fault_n` is 1 exactly when the synchronised enable is 1, the synchronised supply undervoltage is 0 and no trip fault is held. Whenever `fault_n` is 0, all gates are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_in | input | 1 | Global enable, 1 allows switching |
| trip_in | input | 1 | Over-current comparator output, 1 = over-current |
| vdd_uv_in | input | 1 | Main driver supply undervoltage, 1 = low |
| hs_uv_in | input | 3 | Per-phase high-side supply undervoltage, 1 = low |
| pwm_hi_in | input | 3 | High-side PWM commands |
| pwm_lo_in | input | 3 | Low-side PWM commands |
| gate_hi | output | 3 | High-side gate enables |
| gate_lo | output | 3 | Low-side gate enables |
| fault_n | output | 1 | Active-low fault flag |

## Verification
The bench targets the recovery rules that differ between the three protection paths:
- A design that reused the trip hold timer for the supply path would keep `fault_n` low for thousands of cycles after the supply recovered.
- A design that cleared the high-side lockout when the supply recovered would turn the gate back on in the middle of a command.
- A trip glitch one cycle shorter than the blanking window must leave the flag untouched. A blanking counter that is off by one would report a trip.

The bench also measures the exact shutdown, release and command latencies, and sends on pulses and off gaps just under the filter width. A random phase then mixes every input against the cycle-level model.

// File: rtl/gg_pkg.sv
package gg_pkg;
    localparam int NPH         = 3;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_t;

    typedef struct packed {
        logic           en;
        logic           vdd_uv;
        logic           trip;
        logic [NPH-1:0] hs_uv;
        logic [NPH-1:0] cmd_hi;
        logic [NPH-1:0] cmd_lo;
    } raw_in_t;

    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic leg_t leg_drive(input logic run, input logic hi,
                                       input logic lo, input logic hs_block);
        leg_t r;
        r.hi = run & hi & ~lo & ~hs_block;
        r.lo = run & lo & ~hi;
        return r;
    endfunction
endpackage

// File: rtl/gg_sync.sv
module gg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gg_pulse_filter.sv
module gg_pulse_filter #(
    parameter int W     = 1,
    parameter int MINPW = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int            CW   = gg_pkg::cnt_w(MINPW);
    localparam logic [CW-1:0] LAST = CW'(MINPW - 1);

    for (genvar c = 0; c < W; c++) begin : g_ch
        logic [CW-1:0] run;
        logic          lvl;

        always_ff @(posedge clk) begin
            if (rst) begin
                run <= '0;
                lvl <= 1'b0;
            end else if (d[c] == lvl) begin
                run <= '0;
            end else if (run >= LAST) begin
                lvl <= d[c];
                run <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end

        assign q[c] = lvl;
    end
endmodule

// File: rtl/gg_trip_guard.sv
module gg_trip_guard #(
    parameter int BLANK = 18,
    parameter int HOLD  = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic trip_s,
    output logic trip_fault
);
    localparam int            BW      = gg_pkg::cnt_w(BLANK);
    localparam int            HW      = gg_pkg::cnt_w(HOLD);
    localparam logic [BW-1:0] B_LAST  = BW'(BLANK - 1);
    localparam logic [HW-1:0] H_LOAD  = HW'(HOLD);
    localparam logic [HW-1:0] H_ONE   = HW'(1);

    logic [BW-1:0] blank_run;
    logic [HW-1:0] hold_left;
    logic          fault_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            blank_run <= '0;
            hold_left <= H_LOAD;
            fault_r   <= 1'b0;
        end else if (!fault_r) begin
            hold_left <= H_LOAD;
            if (!trip_s) begin
                blank_run <= '0;
            end else if (blank_run >= B_LAST) begin
                fault_r   <= 1'b1;
                blank_run <= '0;
            end else begin
                blank_run <= blank_run + 1'b1;
            end
        end else begin
            blank_run <= '0;
            if (trip_s) begin
                hold_left <= H_LOAD;
            end else if (hold_left <= H_ONE) begin
                fault_r <= 1'b0;
            end else begin
                hold_left <= hold_left - 1'b1;
            end
        end
    end

    assign trip_fault = fault_r;
endmodule

// File: rtl/gg_hs_lock.sv
module gg_hs_lock #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hs_uv,
    input  logic [N-1:0] cmd_hi,
    output logic [N-1:0] block
);
    logic [N-1:0] lock_r;

    always_ff @(posedge clk) begin
        if (rst) lock_r <= '0;
        else     lock_r <= hs_uv | (lock_r & cmd_hi);
    end

    assign block = hs_uv | lock_r;
endmodule

// File: rtl/gg_top.sv
module gg_top
    import gg_pkg::*;
#(
    parameter int BLANK_CYC = 18,
    parameter int HOLD_CYC  = 100000,
    parameter int MINPW_CYC = 50
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en_in,
    input  logic           trip_in,
    input  logic           vdd_uv_in,
    input  logic [NPH-1:0] hs_uv_in,
    input  logic [NPH-1:0] pwm_hi_in,
    input  logic [NPH-1:0] pwm_lo_in,
    output logic [NPH-1:0] gate_hi,
    output logic [NPH-1:0] gate_lo,
    output logic           fault_n
);
    localparam int RAW_W = $bits(raw_in_t);

    raw_in_t          raw_a, raw_s;
    logic             en_s, vdd_uv_s, trip_s;
    logic [NPH-1:0]   hs_uv_s;
    logic [2*NPH-1:0] cmd_f;
    logic [NPH-1:0]   cmd_hi_f, cmd_lo_f, hs_block;
    logic             trip_fault, run;
    logic             fault_n_r;

    always_comb begin
        raw_a.en     = en_in;
        raw_a.vdd_uv = vdd_uv_in;
        raw_a.trip   = trip_in;
        raw_a.hs_uv  = hs_uv_in;
        raw_a.cmd_hi = pwm_hi_in;
        raw_a.cmd_lo = pwm_lo_in;
    end

    gg_sync #(.W(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw_a), .q(raw_s)
    );

    assign en_s     = raw_s.en;
    assign vdd_uv_s = raw_s.vdd_uv;
    assign trip_s   = raw_s.trip;
    assign hs_uv_s  = raw_s.hs_uv;

    gg_pulse_filter #(.W(2*NPH), .MINPW(MINPW_CYC)) u_filt (
        .clk(clk), .rst(rst), .d({raw_s.cmd_hi, raw_s.cmd_lo}), .q(cmd_f)
    );

    assign cmd_hi_f = cmd_f[2*NPH-1:NPH];
    assign cmd_lo_f = cmd_f[NPH-1:0];

    gg_trip_guard #(.BLANK(BLANK_CYC), .HOLD(HOLD_CYC)) u_trip (
        .clk(clk), .rst(rst), .trip_s(trip_s), .trip_fault(trip_fault)
    );

    gg_hs_lock #(.N(NPH)) u_hs (
        .clk(clk), .rst(rst), .hs_uv(hs_uv_s), .cmd_hi(cmd_hi_f), .block(hs_block)
    );

    assign run = en_s & ~vdd_uv_s & ~trip_fault;

    for (genvar p = 0; p < NPH; p++) begin : g_leg
        leg_t nxt;
        logic hi_r, lo_r;

        assign nxt = leg_drive(run, cmd_hi_f[p], cmd_lo_f[p], hs_block[p]);

        always_ff @(posedge clk) begin
            if (rst) begin
                hi_r <= 1'b0;
                lo_r <= 1'b0;
            end else begin
                hi_r <= nxt.hi;
                lo_r <= nxt.lo;
            end
        end

        assign gate_hi[p] = hi_r;
        assign gate_lo[p] = lo_r;
    end

    always_ff @(posedge clk) begin
        if (rst) fault_n_r <= 1'b0;
        else     fault_n_r <= run;
    end

    assign fault_n = fault_n_r;
endmodule

// File: rtl/gg_chk.sv
module gg_chk
    import gg_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [NPH-1:0] gate_hi,
    input logic [NPH-1:0] gate_lo,
    input logic           fault_n,
    input logic           en_s,
    input logic           vdd_uv_s,
    input logic           trip_s,
    input logic [NPH-1:0] hs_uv_s,
    input logic           trip_fault
);
    assert_no_shoot_R2: assert property (@(posedge clk) disable iff (rst)
        (gate_hi & gate_lo) == '0);

    assert_flag_gates_R11: assert property (@(posedge clk) disable iff (rst)
        !fault_n |-> (gate_hi == '0 && gate_lo == '0));

    assert_disable_R3: assert property (@(posedge clk) disable iff (rst)
        !en_s |=> !fault_n);

    assert_trip_off_R5: assert property (@(posedge clk) disable iff (rst)
        trip_fault |=> (gate_hi == '0 && gate_lo == '0 && !fault_n));

    assert_hold_clear_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(trip_fault) |-> (!trip_s && !$past(trip_s)));

    assert_vdd_off_R7: assert property (@(posedge clk) disable iff (rst)
        vdd_uv_s |=> (!fault_n && gate_lo == '0));

    assert_hs_off_R8: assert property (@(posedge clk) disable iff (rst)
        (hs_uv_s != '0) |=> ((gate_hi & $past(hs_uv_s)) == '0));
endmodule

bind gg_top gg_chk u_chk (
    .clk(clk), .rst(rst), .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n),
    .en_s(en_s), .vdd_uv_s(vdd_uv_s), .trip_s(trip_s), .hs_uv_s(hs_uv_s),
    .trip_fault(trip_fault)
);

// File: tb/tb_gg_top.sv
module tb_gg_top;
    import gg_pkg::*;

    localparam int B = 5;
    localparam int H = 60;
    localparam int P = 4;

    logic           clk = 1'b0, rst = 1'b1;
    logic           en_in = 1'b0, trip_in = 1'b0, vdd_uv_in = 1'b0;
    logic [NPH-1:0] hs_uv_in = '0, pwm_hi_in = '0, pwm_lo_in = '0;
    logic [NPH-1:0] gate_hi, gate_lo;
    logic           fault_n;

    always #4 clk = ~clk;

    gg_top #(.BLANK_CYC(B), .HOLD_CYC(H), .MINPW_CYC(P)) dut (
        .clk(clk), .rst(rst), .en_in(en_in), .trip_in(trip_in), .vdd_uv_in(vdd_uv_in),
        .hs_uv_in(hs_uv_in), .pwm_hi_in(pwm_hi_in), .pwm_lo_in(pwm_lo_in),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n)
    );

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit    started = 0;

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // behavioural reference model
    typedef struct packed {
        logic       en;
        logic       vdd;
        logic       trip;
        logic [2:0] hs;
        logic [2:0] hi;
        logic [2:0] lo;
    } smp_t;

    smp_t       hist[$];
    smp_t       ms;
    logic [2:0] f_hi, f_lo, lock, e_hi, e_lo;
    logic       e_fn;
    int         run_hi[3], run_lo[3];
    int         brun, hleft;
    bit         tf, live;

    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
            hist.push_back('0);
            hist.push_back('0);
            f_hi = '0; f_lo = '0; lock = '0; e_hi = '0; e_lo = '0; e_fn = 1'b0;
            for (int p = 0; p < 3; p++) begin run_hi[p] = 0; run_lo[p] = 0; end
            brun = 0; hleft = H; tf = 0;
            started = 1;
        end else begin
            ms   = hist[0];
            live = ms.en & ~ms.vdd & ~tf;
            for (int p = 0; p < 3; p++) begin
                e_hi[p] = live & f_hi[p] & ~f_lo[p] & ~(ms.hs[p] | lock[p]);
                e_lo[p] = live & f_lo[p] & ~f_hi[p];
            end
            e_fn = live;
            lock = ms.hs | (lock & f_hi);
            if (!tf) begin
                hleft = H;
                if (!ms.trip) brun = 0;
                else if (brun >= B - 1) begin tf = 1; brun = 0; end
                else brun++;
            end else begin
                brun = 0;
                if (ms.trip) hleft = H;
                else if (hleft <= 1) tf = 0;
                else hleft--;
            end
            for (int p = 0; p < 3; p++) begin
                if (ms.hi[p] == f_hi[p]) run_hi[p] = 0;
                else if (run_hi[p] >= P - 1) begin f_hi[p] = ms.hi[p]; run_hi[p] = 0; end
                else run_hi[p]++;
                if (ms.lo[p] == f_lo[p]) run_lo[p] = 0;
                else if (run_lo[p] >= P - 1) begin f_lo[p] = ms.lo[p]; run_lo[p] = 0; end
                else run_lo[p]++;
            end
            hist.push_back({en_in, vdd_uv_in, trip_in, hs_uv_in, pwm_hi_in, pwm_lo_in});
            void'(hist.pop_front());
        end
    end

    always @(negedge clk) begin
        if (started) begin
            chk(gate_hi === e_hi && gate_lo === e_lo, cur_req,
                {2'b0, gate_hi, gate_lo}, {2'b0, e_hi, e_lo});
            chk(fault_n === e_fn, "R11", {7'b0, fault_n}, {7'b0, e_fn});
        end
    end

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    logic mx, mn;

    initial begin
        step(2);
        chk(gate_hi == 0 && gate_lo == 0 && fault_n == 0, "R1",
            {1'b0, gate_hi, gate_lo, fault_n}, 8'h00);
        step(3);
        rst = 1'b0;
        step(1);
        chk(gate_hi == 0 && gate_lo == 0 && fault_n == 0, "R1",
            {1'b0, gate_hi, gate_lo, fault_n}, 8'h00);

        cur_req = "R10";
        en_in = 1'b1;
        step(10);
        chk(fault_n == 1, "R11", {7'b0, fault_n}, 8'h01);
        pwm_hi_in = 3'b001;
        step(2 + P);
        chk(gate_hi == 3'b000, "R10", {5'b0, gate_hi}, 8'h00);
        step(1);
        chk(gate_hi == 3'b001, "R10", {5'b0, gate_hi}, 8'h01);
        pwm_lo_in = 3'b100;
        step(12);
        chk(gate_lo == 3'b100 && gate_hi == 3'b001, "R10", {2'b0, gate_hi, gate_lo}, 8'h0C);

        cur_req = "R2";
        pwm_hi_in[1] = 1'b1; pwm_lo_in[1] = 1'b1;
        step(12);
        chk(gate_hi[1] == 0 && gate_lo[1] == 0, "R2", {6'b0, gate_hi[1], gate_lo[1]}, 8'h00);
        pwm_hi_in[1] = 1'b0; pwm_lo_in[1] = 1'b0;
        step(12);

        cur_req = "R9";
        mx = 1'b0;
        pwm_lo_in[0] = 1'b1;
        repeat (P - 1) begin step(1); mx |= gate_lo[0]; end
        pwm_lo_in[0] = 1'b0;
        repeat (15) begin step(1); mx |= gate_lo[0]; end
        chk(mx == 0, "R9", {7'b0, mx}, 8'h00);
        mn = 1'b1;
        pwm_hi_in[0] = 1'b0;
        repeat (P - 1) begin step(1); mn &= gate_hi[0]; end
        pwm_hi_in[0] = 1'b1;
        repeat (15) begin step(1); mn &= gate_hi[0]; end
        chk(mn == 1, "R9", {7'b0, mn}, 8'h01);
        mx = 1'b0;
        pwm_lo_in[1] = 1'b1;
        repeat (P + 2) begin step(1); mx |= gate_lo[1]; end
        pwm_lo_in[1] = 1'b0;
        repeat (15) begin step(1); mx |= gate_lo[1]; end
        chk(mx == 1, "R9", {7'b0, mx}, 8'h01);

        cur_req = "R3";
        en_in = 1'b0;
        step(5);
        chk(gate_hi == 0 && gate_lo == 0 && fault_n == 0, "R3",
            {1'b0, gate_hi, gate_lo, fault_n}, 8'h00);
        en_in = 1'b1;
        step(12);
        chk(gate_hi == 3'b001 && fault_n == 1, "R3", {4'b0, gate_hi, fault_n}, 8'h03);

        cur_req = "R4";
        mn = 1'b1;
        trip_in = 1'b1;
        repeat (B - 1) begin step(1); mn &= fault_n; end
        trip_in = 1'b0;
        repeat (20) begin step(1); mn &= fault_n & gate_hi[0]; end
        chk(mn == 1, "R4", {7'b0, mn}, 8'h01);

        cur_req = "R5";
        trip_in = 1'b1;
        step(2 + B);
        chk(gate_hi == 3'b001 && fault_n == 1, "R5", {4'b0, gate_hi, fault_n}, 8'h03);
        step(1);
        chk(gate_hi == 0 && gate_lo == 0 && fault_n == 0, "R5",
            {1'b0, gate_hi, gate_lo, fault_n}, 8'h00);

        cur_req = "R6";
        step(10);
        trip_in = 1'b0;
        step(H + 2);
        chk(fault_n == 0 && gate_hi == 0, "R6", {4'b0, gate_hi, fault_n}, 8'h00);
        step(1);
        chk(fault_n == 1 && gate_hi == 3'b001, "R6", {4'b0, gate_hi, fault_n}, 8'h03);

        cur_req = "R7";
        vdd_uv_in = 1'b1;
        step(2);
        chk(fault_n == 1, "R7", {7'b0, fault_n}, 8'h01);
        step(1);
        chk(fault_n == 0 && gate_hi == 0 && gate_lo == 0, "R7",
            {1'b0, gate_hi, gate_lo, fault_n}, 8'h00);
        step(10);
        vdd_uv_in = 1'b0;
        step(2);
        chk(fault_n == 0, "R7", {7'b0, fault_n}, 8'h00);
        step(1);
        chk(fault_n == 1 && gate_hi == 3'b001, "R7", {4'b0, gate_hi, fault_n}, 8'h03);

        cur_req = "R8";
        pwm_lo_in = 3'b010;
        step(12);
        hs_uv_in[0] = 1'b1;
        step(3);
        chk(gate_hi == 0 && gate_lo == 3'b010 && fault_n == 1, "R8",
            {1'b0, gate_hi, gate_lo, fault_n}, 8'h05);
        hs_uv_in[0] = 1'b0;
        step(20);
        chk(gate_hi[0] == 0, "R8", {7'b0, gate_hi[0]}, 8'h00);
        pwm_hi_in[0] = 1'b0;
        step(12);
        pwm_hi_in[0] = 1'b1;
        step(12);
        chk(gate_hi[0] == 1, "R8", {7'b0, gate_hi[0]}, 8'h01);

        cur_req = "R10";
        for (int i = 0; i < 4000; i++) begin
            step(1);
            if ($urandom_range(0, 7) == 0) begin
                int k = $urandom_range(0, 2);
                pwm_hi_in[k] = ~pwm_hi_in[k];
            end
            if ($urandom_range(0, 7) == 0) begin
                int k = $urandom_range(0, 2);
                pwm_lo_in[k] = ~pwm_lo_in[k];
            end
            if ($urandom_range(0, 149) == 0) begin
                int k = $urandom_range(0, 2);
                hs_uv_in[k] = ~hs_uv_in[k];
            end
            if ($urandom_range(0, 199) == 0) trip_in = ~trip_in;
            if ($urandom_range(0, 299) == 0) vdd_uv_in = ~vdd_uv_in;
            if ($urandom_range(0, 299) == 0) en_in = ~en_in;
        end
        trip_in = 1'b0; vdd_uv_in = 1'b0; hs_uv_in = '0; en_in = 1'b1;
        pwm_hi_in = '0; pwm_lo_in = '0;
        step(H + 20);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule